// File: doc/BRIEF.md
# Tracker Event Word Formatter

This block turns one trigger's worth of digitized hit data from two front-end sources, called A and B, into a stream of 21-bit words. It sends one word per clock. Each source supplies a hit mask over `NCH` channels and, for every channel, an 8-bit time value and an 8-bit charge value. These inputs are captured in the cycle that a trigger is accepted.

For each accepted trigger the block sends the following words, in this order:
- a trigger marker word;
- a header word carrying an 8-bit event sync number and the count of words that follow the header;
- the hit-mask bytes of source A, then those of source B;
- a channel section for source A, then one for source B.

Each channel section lists the indices of the hit channels, then their time bytes, then their charge bytes, packed two bytes per word. A half word left at the end of a section is sent as a half-filled word. A source with no hits sends a single fill word. While no event is being sent, the output carries the null word.

Bit 0 of every word is reserved for the serial link's sync bit and is driven low here. Serialization happens downstream and is not part of this block.

Top module: `tracker_event_fmt`

## Requirements
- R1: After reset, and whenever no event is being sent, `word_o` is all zeros (the null word).
- R2: A trigger seen at a clock edge while the block is idle is accepted. The word registered at that edge is the trigger word: bits 20..9 are all ones and bits 8..0 are zero.
- R3: Every word has even parity over bits 20..17 and 16..1 taken together, with bit 17 as the parity bit. Bit 0 is always 0.
- R4: The word after the trigger word is the header. Bits 20..18 hold 110, bits 16..9 hold the event sync number, and bits 8..1 hold the number of words from the one after the header through the last word of the event, saturating at 255.
- R5: The event sync number is 0 for the first event after reset. It increases by one for each accepted trigger and wraps from 255 to 0.
- R6: After the header come the hit-mask words, source A first and then source B. Mask byte n holds channels 8n..8n+7, with bit i of the byte being channel 8n+i. Bytes go out in ascending order, two per word of type 101, with the earlier byte in bits 16..9. When a source has an odd number of mask bytes, its last byte uses a half word: for source A it is type 100 with the byte in bits 16..9 and bits 8..1 zero; for source B it is type 011 with the byte in bits 8..1 and bits 16..9 zero.
- R7: After both masks come the channel sections, source A first and then source B. For a source with h hits, the section is a 3h-byte stream: the hit channel indices in ascending order, then their time bytes in the same order, then their charge bytes in the same order. The stream is packed two bytes per type-101 word, with the earlier byte in bits 16..9.
- R8: When a channel stream has an odd byte count (h odd), its final byte is sent as a half word using the source-specific rule of R6: type 100 for A, type 011 for B.
- R9: A source with no hits sends exactly one fill word, type 010, with bits 16..1 zero, as its channel section.
- R10: A trigger present in the cycle the last word of an event is on the output is accepted. The next word is a trigger word, with no null word in between.
- R11: A trigger present while any other event word is on the output is ignored. The event continues unchanged and the sync number does not advance.
- R12: Hit, time and charge inputs are used only from the cycle in which a trigger is accepted. Later changes do not alter the event being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger request, sampled every clock edge |
| hit_a_i | input | NCH | Source A hit mask, bit c = channel c |
| time_a_i | input | 8*NCH | Source A time bytes, channel c at bits 8c+7..8c |
| charge_a_i | input | 8*NCH | Source A charge bytes, channel c at bits 8c+7..8c |
| hit_b_i | input | NCH | Source B hit mask |
| time_b_i | input | 8*NCH | Source B time bytes |
| charge_b_i | input | 8*NCH | Source B charge bytes |
| word_o | output | 21 | Registered output word |

## Verification
Accepting a new trigger can fall in the same cycle as sending the final word of the previous event. The bench provokes this by raising the trigger exactly while the last channel word of source B is on the output, with fresh inputs applied at the same time. It judges the result by requiring that the following sample is a trigger word rather than a null word, and that the header after it carries the next sync number and describes the new inputs. A trigger raised a few words earlier, in the middle of an event, serves as the contrast case: it must leave both the stream and the sync number untouched.

// File: rtl/tracker_fmt_pkg.sv
package tracker_fmt_pkg;

    localparam int WORD_W  = 21;
    localparam int BYTE_W  = 8;
    localparam int CNT_SAT = 255;

    // Type codes live in bits 20..18; downstream decoders depend on them.
    typedef enum logic [2:0] {
        KIND_NULL    = 3'b000,
        KIND_FILL    = 3'b010,
        KIND_HALF_LO = 3'b011,  // one byte in bits 8..1
        KIND_HALF_HI = 3'b100,  // one byte in bits 16..9
        KIND_DATA    = 3'b101,
        KIND_HEAD    = 3'b110,
        KIND_TRIG    = 3'b111
    } word_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRIG,
        ST_HEAD,
        ST_MAP_A,
        ST_MAP_B,
        ST_CH_A,
        ST_CH_B
    } seq_state_e;

    localparam logic [WORD_W-1:0] TRIG_WORD = 21'h1FFE00;

endpackage

// File: rtl/tracker_word_pack.sv
module tracker_word_pack
    import tracker_fmt_pkg::*;
(
    input  word_kind_e              kind_i,
    input  logic [BYTE_W-1:0]       hi_i,
    input  logic [BYTE_W-1:0]       lo_i,
    output logic [WORD_W-1:0]       word_o
);

    logic par;

    always_comb begin
        par = ^{kind_i, hi_i, lo_i};
        if (kind_i == KIND_NULL) begin
            word_o = '0;
        end else begin
            word_o = {kind_i, par, hi_i, lo_i, 1'b0};
        end
    end

endmodule

// File: rtl/tracker_hit_gather.sv
module tracker_hit_gather
    import tracker_fmt_pkg::*;
#(
    parameter int NCH = 24,
    parameter int CW  = $clog2(NCH + 1),
    parameter int IW  = $clog2(3 * NCH + 1)
) (
    input  logic [NCH-1:0]          hit_i,
    input  logic [NCH*BYTE_W-1:0]   time_i,
    input  logic [NCH*BYTE_W-1:0]   charge_i,
    input  logic [IW-1:0]           idx0_i,
    input  logic [IW-1:0]           idx1_i,
    output logic [CW-1:0]           nhit_o,
    output logic [BYTE_W-1:0]       byte0_o,
    output logic [BYTE_W-1:0]       byte1_o
);

    logic [CW-1:0] nhit;

    // Byte j of the stream: index of hit j, then times, then charges.
    function automatic logic [BYTE_W-1:0] stream_byte(
        input logic [IW-1:0]          idx,
        input logic [CW-1:0]          n,
        input logic [NCH-1:0]         h,
        input logic [NCH*BYTE_W-1:0]  t,
        input logic [NCH*BYTE_W-1:0]  q
    );
        logic [BYTE_W-1:0] r;
        logic [IW-1:0]     rank;
        logic [IW-1:0]     seen;
        logic [1:0]        part;
        r    = '0;
        seen = '0;
        if (idx < IW'(n)) begin
            part = 2'd0;
            rank = idx;
        end else if (idx < IW'(2 * int'(n))) begin
            part = 2'd1;
            rank = idx - IW'(n);
        end else begin
            part = 2'd2;
            rank = idx - IW'(2 * int'(n));
        end
        for (int c = 0; c < NCH; c++) begin
            if (h[c]) begin
                if (seen == rank) begin
                    case (part)
                        2'd0:    r = BYTE_W'(c);
                        2'd1:    r = t[c*BYTE_W +: BYTE_W];
                        default: r = q[c*BYTE_W +: BYTE_W];
                    endcase
                end
                seen = seen + 1'b1;
            end
        end
        return r;
    endfunction

    assign nhit   = CW'($countones(hit_i));
    assign nhit_o = nhit;

    always_comb begin
        byte0_o = stream_byte(idx0_i, nhit, hit_i, time_i, charge_i);
        byte1_o = stream_byte(idx1_i, nhit, hit_i, time_i, charge_i);
    end

endmodule

// File: rtl/tracker_event_fmt.sv
module tracker_event_fmt
    import tracker_fmt_pkg::*;
#(
    parameter int NCH = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig_i,
    input  logic [NCH-1:0]          hit_a_i,
    input  logic [NCH*8-1:0]        time_a_i,
    input  logic [NCH*8-1:0]        charge_a_i,
    input  logic [NCH-1:0]          hit_b_i,
    input  logic [NCH*8-1:0]        time_b_i,
    input  logic [NCH*8-1:0]        charge_b_i,
    output logic [20:0]             word_o
);

    localparam int CW        = $clog2(NCH + 1);
    localparam int IW        = $clog2(3 * NCH + 1);
    localparam int MAP_BYTES = NCH / BYTE_W;
    localparam int MAP_WORDS = (MAP_BYTES + 1) / 2;
    localparam bit MAP_ODD   = (MAP_BYTES % 2) == 1;
    localparam int DW        = NCH * BYTE_W;

    typedef struct packed {
        seq_state_e        st;
        logic [IW-1:0]     wi;
        logic [7:0]        sync_cnt;
        logic [7:0]        ev_sync;
        logic [NCH-1:0]    hit_a;
        logic [DW-1:0]     tm_a;
        logic [DW-1:0]     qa;
        logic [NCH-1:0]    hit_b;
        logic [DW-1:0]     tm_b;
        logic [DW-1:0]     qb;
    } fmt_reg_t;

    fmt_reg_t r_d, r_q;
    logic [WORD_W-1:0] word_d, word_q;

    logic [CW-1:0]     nhit_a, nhit_b;
    logic [BYTE_W-1:0] a_b0, a_b1, b_b0, b_b1;
    logic [IW-1:0]     idx0, idx1;
    logic [IW-1:0]     chw_a, chw_b;
    logic              last_word;
    logic              accept;

    word_kind_e        kind;
    logic [BYTE_W-1:0] hi_byte, lo_byte;

    function automatic logic [IW-1:0] chan_words(input logic [CW-1:0] n);
        if (n == '0) return IW'(1);
        return IW'((3 * int'(n) + 1) / 2);
    endfunction

    function automatic logic [BYTE_W-1:0] map_byte(input logic [NCH-1:0] h,
                                                    input logic [IW-1:0] n);
        logic [BYTE_W-1:0] r;
        r = '0;
        for (int b = 0; b < MAP_BYTES; b++) begin
            if (IW'(b) == n) r = h[b*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

    // Two gather units, one per source, share the word-relative indices.
    tracker_hit_gather #(.NCH(NCH), .CW(CW), .IW(IW)) u_gather_a (
        .hit_i    (r_q.hit_a),
        .time_i   (r_q.tm_a),
        .charge_i (r_q.qa),
        .idx0_i   (idx0),
        .idx1_i   (idx1),
        .nhit_o   (nhit_a),
        .byte0_o  (a_b0),
        .byte1_o  (a_b1)
    );

    tracker_hit_gather #(.NCH(NCH), .CW(CW), .IW(IW)) u_gather_b (
        .hit_i    (r_q.hit_b),
        .time_i   (r_q.tm_b),
        .charge_i (r_q.qb),
        .idx0_i   (idx0),
        .idx1_i   (idx1),
        .nhit_o   (nhit_b),
        .byte0_o  (b_b0),
        .byte1_o  (b_b1)
    );

    assign chw_a     = chan_words(nhit_a);
    assign chw_b     = chan_words(nhit_b);
    assign last_word = (r_q.st == ST_CH_B) && (r_q.wi == chw_b - 1'b1);
    assign accept    = trig_i && ((r_q.st == ST_IDLE) || last_word);

    // Sequencing: which word goes out next.
    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_TRIG: r_d.st = ST_HEAD;
            ST_HEAD: begin
                r_d.st = ST_MAP_A;
                r_d.wi = '0;
            end
            ST_MAP_A: begin
                if (r_q.wi == IW'(MAP_WORDS - 1)) begin
                    r_d.st = ST_MAP_B;
                    r_d.wi = '0;
                end else begin
                    r_d.wi = r_q.wi + 1'b1;
                end
            end
            ST_MAP_B: begin
                if (r_q.wi == IW'(MAP_WORDS - 1)) begin
                    r_d.st = ST_CH_A;
                    r_d.wi = '0;
                end else begin
                    r_d.wi = r_q.wi + 1'b1;
                end
            end
            ST_CH_A: begin
                if (r_q.wi == chw_a - 1'b1) begin
                    r_d.st = ST_CH_B;
                    r_d.wi = '0;
                end else begin
                    r_d.wi = r_q.wi + 1'b1;
                end
            end
            ST_CH_B: begin
                if (last_word) begin
                    r_d.st = ST_IDLE;
                    r_d.wi = '0;
                end else begin
                    r_d.wi = r_q.wi + 1'b1;
                end
            end
            default: ;
        endcase
        if (accept) begin
            r_d.st       = ST_TRIG;
            r_d.wi       = '0;
            r_d.ev_sync  = r_q.sync_cnt;
            r_d.sync_cnt = r_q.sync_cnt + 1'b1;
            r_d.hit_a    = hit_a_i;
            r_d.tm_a     = time_a_i;
            r_d.qa       = charge_a_i;
            r_d.hit_b    = hit_b_i;
            r_d.tm_b     = time_b_i;
            r_d.qb       = charge_b_i;
        end
    end

    assign idx0 = IW'({r_d.wi, 1'b0});
    assign idx1 = IW'({r_d.wi, 1'b1});

    // Word contents for the state chosen above.
    always_comb begin
        int total;
        kind    = KIND_NULL;
        hi_byte = '0;
        lo_byte = '0;
        total   = 2 * MAP_WORDS + int'(chw_a) + int'(chw_b);
        case (r_d.st)
            ST_TRIG: begin
                kind    = KIND_TRIG;
                hi_byte = 8'hFF;
            end
            ST_HEAD: begin
                kind    = KIND_HEAD;
                hi_byte = r_d.ev_sync;
                lo_byte = (total > CNT_SAT) ? 8'(CNT_SAT) : 8'(total);
            end
            ST_MAP_A: begin
                if (MAP_ODD && r_d.wi == IW'(MAP_WORDS - 1)) begin
                    kind    = KIND_HALF_HI;
                    hi_byte = map_byte(r_q.hit_a, idx0);
                end else begin
                    kind    = KIND_DATA;
                    hi_byte = map_byte(r_q.hit_a, idx0);
                    lo_byte = map_byte(r_q.hit_a, idx1);
                end
            end
            ST_MAP_B: begin
                if (MAP_ODD && r_d.wi == IW'(MAP_WORDS - 1)) begin
                    kind    = KIND_HALF_LO;
                    lo_byte = map_byte(r_q.hit_b, idx0);
                end else begin
                    kind    = KIND_DATA;
                    hi_byte = map_byte(r_q.hit_b, idx0);
                    lo_byte = map_byte(r_q.hit_b, idx1);
                end
            end
            ST_CH_A: begin
                if (nhit_a == '0) begin
                    kind = KIND_FILL;
                end else if (nhit_a[0] && r_d.wi == chw_a - 1'b1) begin
                    kind    = KIND_HALF_HI;
                    hi_byte = a_b0;
                end else begin
                    kind    = KIND_DATA;
                    hi_byte = a_b0;
                    lo_byte = a_b1;
                end
            end
            ST_CH_B: begin
                if (nhit_b == '0) begin
                    kind = KIND_FILL;
                end else if (nhit_b[0] && r_d.wi == chw_b - 1'b1) begin
                    kind    = KIND_HALF_LO;
                    lo_byte = b_b0;
                end else begin
                    kind    = KIND_DATA;
                    hi_byte = b_b0;
                    lo_byte = b_b1;
                end
            end
            default: ;
        endcase
    end

    tracker_word_pack u_pack (
        .kind_i (kind),
        .hi_i   (hi_byte),
        .lo_i   (lo_byte),
        .word_o (word_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            word_q <= '0;
        end else begin
            r_q    <= r_d;
            word_q <= word_d;
        end
    end

    assign word_o = word_q;

    // R3
    parity_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (^word_o[20:1]) == 1'b0);

    // R3
    sync_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_o[0] == 1'b0);

    // R2
    trig_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && r_q.st == ST_IDLE) |=> (word_o == TRIG_WORD));

    // R4
    head_after_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o[20:18] == 3'b111) |=> (word_o[20:18] == 3'b110));

    // R11
    trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && !last_word) |=> (word_o[20:18] != 3'b111));

    // R10
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && last_word) |=> (word_o == TRIG_WORD));

endmodule

// File: tb/sim_tracker_event_fmt.sv
module sim_tracker_event_fmt;

    localparam int NCH = 24;
    localparam int DW  = NCH * 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           trig_i = 1'b0;
    logic [NCH-1:0] hit_a_i = '0, hit_b_i = '0;
    logic [DW-1:0]  time_a_i = '0, charge_a_i = '0, time_b_i = '0, charge_b_i = '0;
    logic [20:0]    word_o;

    int nchk = 0;
    int nbad = 0;
    int exp_sync = 0;
    bit finished = 1'b0;

    logic [20:0] exp_w [0:127];
    string       exp_r [0:127];
    int          exp_n;

    always #4 clk = ~clk;

    tracker_event_fmt #(.NCH(NCH)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_i),
        .hit_a_i    (hit_a_i),
        .time_a_i   (time_a_i),
        .charge_a_i (charge_a_i),
        .hit_b_i    (hit_b_i),
        .time_b_i   (time_b_i),
        .charge_b_i (charge_b_i),
        .word_o     (word_o)
    );

    function automatic logic [20:0] mk(input logic [2:0] k, input logic [7:0] hi, input logic [7:0] lo);
        logic p;
        p = ^{k, hi, lo};
        return {k, p, hi, lo, 1'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [20:0] act, input logic [20:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic push(input logic [20:0] w, input string req);
        exp_w[exp_n] = w;
        exp_r[exp_n] = req;
        exp_n++;
    endtask

    task automatic push_map(input logic [NCH-1:0] h, input bit is_b);
        push(mk(3'b101, h[7:0], h[15:8]), "R6 mask");
        if (is_b) push(mk(3'b011, 8'h00, h[23:16]), "R6 mask half");
        else      push(mk(3'b100, h[23:16], 8'h00), "R6 mask half");
    endtask

    task automatic push_chan(input logic [NCH-1:0] h, input logic [DW-1:0] t,
                             input logic [DW-1:0] q, input bit is_b);
        logic [7:0] bs [0:3*NCH-1];
        int n;
        n = 0;
        for (int c = 0; c < NCH; c++) if (h[c]) begin bs[n] = 8'(c); n++; end
        for (int c = 0; c < NCH; c++) if (h[c]) begin bs[n] = t[c*8 +: 8]; n++; end
        for (int c = 0; c < NCH; c++) if (h[c]) begin bs[n] = q[c*8 +: 8]; n++; end
        if (n == 0) begin
            push(mk(3'b010, 8'h00, 8'h00), "R9 fill");
        end else begin
            for (int k = 0; k < n; k += 2) begin
                if (k + 1 < n)  push(mk(3'b101, bs[k], bs[k+1]), "R7 channel");
                else if (is_b)  push(mk(3'b011, 8'h00, bs[k]), "R8 half");
                else            push(mk(3'b100, bs[k], 8'h00), "R8 half");
            end
        end
    endtask

    task automatic launch(input logic [NCH-1:0] ha, input logic [DW-1:0] ta, input logic [DW-1:0] qa,
                          input logic [NCH-1:0] hb, input logic [DW-1:0] tb, input logic [DW-1:0] qb,
                          input bit scramble);
        int cnt;
        exp_n = 0;
        push(21'h1FFE00, "R2 trigger");
        push('0, "R4 R5 header");
        push_map(ha, 1'b0);
        push_map(hb, 1'b1);
        push_chan(ha, ta, qa, 1'b0);
        push_chan(hb, tb, qb, 1'b1);
        cnt = exp_n - 2;
        exp_w[1] = mk(3'b110, 8'(exp_sync), (cnt > 255) ? 8'd255 : 8'(cnt));
        exp_sync = (exp_sync + 1) % 256;
        hit_a_i = ha; time_a_i = ta; charge_a_i = qa;
        hit_b_i = hb; time_b_i = tb; charge_b_i = qb;
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        if (scramble) begin
            hit_a_i = ~ha; time_a_i = ~ta; charge_a_i = ~qa;
            hit_b_i = ~hb; time_b_i = ~tb; charge_b_i = ~qb;
        end
    endtask

    task automatic follow(input string tag, input int pulse_at);
        for (int i = 0; i < exp_n; i++) begin
            if (i > 0) begin
                @(negedge clk);
                trig_i = 1'b0;
            end
            chk(word_o == exp_w[i], {tag, " ", exp_r[i]}, word_o, exp_w[i]);
            chk((^word_o[20:1]) == 1'b0 && word_o[0] == 1'b0, {tag, " R3 parity"}, word_o, exp_w[i]);
            if (i == pulse_at) trig_i = 1'b1;
        end
    endtask

    task automatic expect_null(input string tag);
        @(negedge clk);
        trig_i = 1'b0;
        chk(word_o == '0, {tag, " R1 null"}, word_o, 21'h0);
    endtask

    function automatic logic [DW-1:0] ramp(input int base, input int step);
        logic [DW-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*8 +: 8] = 8'(base + step * c);
        return v;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(word_o == '0, "R1 reset", word_o, 21'h0);
        repeat (3) @(negedge clk);
        chk(word_o == '0, "R1 idle", word_o, 21'h0);
    endtask

    task automatic t_no_hits();
        launch('0, ramp(1, 1), ramp(2, 3), '0, ramp(9, 1), ramp(4, 5), 1'b0);
        follow("no-hits R9", -1);
        expect_null("no-hits");
    endtask

    task automatic t_odd_even();
        launch(24'h000008, ramp(16, 2), ramp(200, 1), 24'h020001, ramp(40, 3), ramp(90, 7), 1'b0);
        follow("odd-even R8", -1);
        expect_null("odd-even");
        launch(24'h810042, ramp(5, 1), ramp(77, 2), 24'h000100, ramp(33, 1), ramp(11, 4), 1'b0);
        follow("even-odd R7", -1);
        expect_null("even-odd");
    endtask

    task automatic t_full();
        launch('1, ramp(1, 7), ramp(255, -1), '1, ramp(3, 5), ramp(128, 3), 1'b0);
        follow("full R7", -1);
        expect_null("full");
    endtask

    task automatic t_hold();
        launch(24'h5A00C3, ramp(8, 9), ramp(60, 2), 24'h0F0F00, ramp(70, 1), ramp(20, 6), 1'b1);
        follow("R12 hold", -1);
        expect_null("R12 hold");
    endtask

    task automatic t_ignore();
        launch(24'h000301, ramp(1, 1), ramp(2, 2), 24'h800000, ramp(3, 3), ramp(4, 4), 1'b0);
        follow("R11 ignore", 3);
        expect_null("R11 ignore");
        launch(24'h000001, ramp(6, 1), ramp(7, 1), '0, ramp(8, 1), ramp(9, 1), 1'b0);
        follow("R11 next sync", -1);
        expect_null("R11 next");
    endtask

    task automatic t_back_to_back();
        launch(24'h030000, ramp(21, 1), ramp(31, 1), 24'h000007, ramp(41, 1), ramp(51, 1), 1'b0);
        follow("R10 first", -1);
        launch(24'h100010, ramp(61, 2), ramp(71, 2), 24'h000000, ramp(81, 1), ramp(91, 1), 1'b0);
        follow("R10 second", -1);
        expect_null("R10 end");
    endtask

    task automatic t_wrap();
        while (exp_sync != 0) begin
            launch('0, '0, '0, '0, '0, '0, 1'b0);
            follow("R5 wrap", -1);
            expect_null("R5 wrap");
        end
        launch(24'h000100, ramp(1, 1), ramp(1, 1), 24'h000100, ramp(2, 1), ramp(2, 1), 1'b0);
        follow("R5 after wrap", -1);
        expect_null("R5 after wrap");
    endtask

    initial begin
        t_reset();
        t_no_hits();
        t_odd_even();
        t_full();
        t_hold();
        t_ignore();
        t_back_to_back();
        t_wrap();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule